// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block drives master-mode transfers on a two-wire serial bus through a separate byte-level bus engine. Software writes a 16-bit control word and a transfer length. The block then requests an addressed start, moves bytes between the bus engine and an external packing buffer one at a time, and closes the transfer with a stop when asked to. Per-byte acknowledge results from the engine steer it. A five-bit status word reports no-acknowledge, access-ready, receive-ready and transmit-ready. Software clears these bits by writing ones.

Two data modes exist. In counted mode a live down-counter, loaded from the length register at start, limits the number of bytes. When it runs out, the stop bit selects between closing the bus transaction and handing control back with access-ready. In repeat mode the count is ignored: the block drains or fills the buffer, flags ready and waits. Each data-register access elsewhere in the system pulses `data_touch`. This resumes data movement while a transfer is open and does nothing while the bus is idle.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the control word, length, live counter and status all read zero, and no engine request is raised.
- R2: A control write stores the written value ANDed with 0xCF86: bit 15 enable, 14 byte order, 10 master, 9 transmit (1 = write to the slave), 2 repeat mode, 1 stop. The start bit (bit 0) always reads back as zero.
- R3: A control write with enable, master and start all set, made while no engine request is pending, issues a start request (req_kind 0) to `tgt_addr` with `req_read` equal to the inverse of bit 9. Without master or enable, no request is raised.
- R4: A start that is not acknowledged sets status bit 1, clears the stop bit and leaves no transfer open.
- R5: In counted transmit, each send request (req_kind 1) carries the head buffer byte and pops it, and each byte decrements the live counter. If the buffer empties while count remains, status bit 4 (transmit-ready) is set and the block waits.
- R6: In counted receive, a receive request (req_kind 2) is issued while count remains and fewer than DEPTH bytes are held. Each received byte is pushed and decrements the counter. A full buffer sets status bit 3 (receive-ready) and pauses.
- R7: When the count is exhausted with stop set, a stop request (req_kind 3) is issued. On completion the stop bit clears, the live counter reloads from the length register, the transmit buffer is flushed and the transfer closes.
- R8: When the count is exhausted without stop, status bit 2 (access-ready) is set, the master bit clears and transmit-ready clears. In receive, receive-ready reflects whether bytes are held.
- R9: In repeat mode the counter is neither tested nor decremented. Transmit sends every buffered byte and then sets transmit-ready. Receive fills the buffer to DEPTH and then sets receive-ready. A set stop bit issues the stop request at once.
- R10: A data byte that is not acknowledged sets status bit 1, clears the stop bit and transmit-ready, and stops further bytes.
- R11: A `data_touch` pulse resumes data movement on an open transfer and has no effect when no transfer is open.
- R12: A control write with enable clear withdraws any pending request on the next cycle and closes the transfer.
- R13: Status bits given in `stat_clr` are cleared. The length register is written by `cnt_we`, and `cnt_live` shows the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| cnt_we | input | 1 | Length register write strobe |
| cnt_wdata | input | CNT_W | Length register write data |
| tgt_addr | input | AW | Slave address for the start request |
| data_touch | input | 1 | Data register accessed; re-run data movement |
| stat_clr | input | 5 | Write-one-to-clear for status bits |
| ctl_q | output | 16 | Current control word |
| cnt_live | output | CNT_W | Live down-counter |
| stat | output | 5 | Status: bit1 no-ack, bit2 access-ready, bit3 receive-ready, bit4 transmit-ready |
| req_valid | output | 1 | Engine request pending |
| req_kind | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| req_addr | output | AW | Address for a start request |
| req_read | output | 1 | Direction for a start request |
| req_wdata | output | 8 | Byte for a send request |
| eng_done | input | 1 | Engine completed the pending request |
| eng_ack | input | 1 | Acknowledge result of a start or send |
| eng_rdata | input | 8 | Byte received by a receive request |
| tx_level | input | LVL_W | Bytes held in the transmit buffer |
| tx_byte | input | 8 | Head byte of the transmit buffer |
| tx_pop | output | 1 | Remove the head transmit byte |
| tx_flush | output | 1 | Empty the transmit buffer |
| rx_level | input | LVL_W | Bytes held in the receive buffer |
| rx_push | output | 1 | Append `rx_byte` to the receive buffer |
| rx_byte | output | 8 | Byte to append |

## Verification
The hardest situation to reach is a counted transfer that pauses partway: the count still has bytes left, but the buffer has run dry on transmit or filled on receive. The block then has to resume on a later `data_touch` and still finish with the right stop-or-hand-back choice. The stimulus gets there by setting the length larger than the buffer contents. Before pulsing `data_touch`, it refills or drains the buffer model, then checks the live counter and the ready flags at each pause. Acknowledge failures come from a per-operation plan in the engine model, so a no-acknowledge can be placed on the start or on any chosen data byte.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int CNT_W = 16,
  parameter int AW    = 7,
  parameter int DEPTH = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [15:0]      ctl_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [AW-1:0]    tgt_addr,
  input  logic             data_touch,
  input  logic [4:0]       stat_clr,
  output logic [15:0]      ctl_q,
  output logic [CNT_W-1:0] cnt_live,
  output logic [4:0]       stat,
  output logic             req_valid,
  output logic [1:0]       req_kind,
  output logic [AW-1:0]    req_addr,
  output logic             req_read,
  output logic [7:0]       req_wdata,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [7:0]       eng_rdata,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [7:0]       tx_byte,
  output logic             tx_pop,
  output logic             tx_flush,
  input  logic [LVL_W-1:0] rx_level,
  output logic             rx_push,
  output logic [7:0]       rx_byte
);

  localparam int B_EN  = 15;
  localparam int B_MST = 10;
  localparam int B_TX  = 9;
  localparam int B_RPT = 2;
  localparam int B_STP = 1;
  localparam int B_STT = 0;
  localparam logic [15:0] CTL_KEEP = 16'hCF86;
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  localparam int S_NACK = 1;
  localparam int S_ARDY = 2;
  localparam int S_RRDY = 3;
  localparam int S_XRDY = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_RUN, ST_SEND, ST_RECV, ST_STOP
  } seq_state_t;

  seq_state_t state;
  logic [15:0]      ctl;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] live;
  logic             open_xfer;

  wire abort = ctl_we && !ctl_wdata[B_EN];
  wire go    = ctl_we && ctl_wdata[B_EN] && ctl_wdata[B_MST] &&
               ctl_wdata[B_STT] && state == ST_IDLE;
  wire tx_has   = tx_level != '0;
  wire rx_room  = rx_level < FULL;

  assign ctl_q     = ctl;
  assign cnt_live  = live;
  assign req_valid = state == ST_ADDR || state == ST_SEND ||
                     state == ST_RECV || state == ST_STOP;
  assign req_kind  = state == ST_SEND ? 2'd1 :
                     state == ST_RECV ? 2'd2 :
                     state == ST_STOP ? 2'd3 : 2'd0;
  assign req_addr  = tgt_addr;
  assign req_read  = !ctl[B_TX];
  assign req_wdata = tx_byte;
  assign rx_byte   = eng_rdata;
  assign tx_pop    = state == ST_SEND && eng_done;
  assign rx_push   = state == ST_RECV && eng_done;
  assign tx_flush  = state == ST_STOP && eng_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ctl       <= '0;
      cnt_q     <= '0;
      live      <= '0;
      open_xfer <= 1'b0;
      stat      <= '0;
    end else begin
      stat <= stat & ~stat_clr;
      stat[0] <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (go)
            state <= ST_ADDR;
          else if (data_touch && open_xfer)
            state <= ST_RUN;
        end
        ST_ADDR: begin
          if (eng_done) begin
            if (eng_ack) begin
              open_xfer <= 1'b1;
              live      <= cnt_q;
              state     <= ST_RUN;
            end else begin
              stat[S_NACK] <= 1'b1;
              ctl[B_STP]   <= 1'b0;
              open_xfer    <= 1'b0;
              state        <= ST_IDLE;
            end
          end
        end
        ST_RUN: begin
          if (ctl[B_RPT]) begin
            if (ctl[B_STP])
              state <= ST_STOP;
            else if (ctl[B_TX]) begin
              if (tx_has) state <= ST_SEND;
              else begin
                stat[S_XRDY] <= 1'b1;
                state        <= ST_IDLE;
              end
            end else begin
              if (rx_room) state <= ST_RECV;
              else begin
                stat[S_RRDY] <= 1'b1;
                state        <= ST_IDLE;
              end
            end
          end else if (live == '0) begin
            if (ctl[B_TX]) stat[S_XRDY] <= 1'b0;
            else           stat[S_RRDY] <= rx_level != '0;
            if (ctl[B_STP])
              state <= ST_STOP;
            else begin
              stat[S_ARDY] <= 1'b1;
              ctl[B_MST]   <= 1'b0;
              state        <= ST_IDLE;
            end
          end else if (ctl[B_TX]) begin
            if (tx_has) state <= ST_SEND;
            else begin
              stat[S_XRDY] <= 1'b1;
              state        <= ST_IDLE;
            end
          end else begin
            if (rx_room) state <= ST_RECV;
            else begin
              stat[S_RRDY] <= 1'b1;
              state        <= ST_IDLE;
            end
          end
        end
        ST_SEND: begin
          if (eng_done) begin
            if (!ctl[B_RPT]) live <= live - ONE;
            if (eng_ack)
              state <= ST_RUN;
            else begin
              stat[S_NACK] <= 1'b1;
              stat[S_XRDY] <= 1'b0;
              ctl[B_STP]   <= 1'b0;
              state        <= ST_IDLE;
            end
          end
        end
        ST_RECV: begin
          if (eng_done) begin
            if (!ctl[B_RPT]) live <= live - ONE;
            stat[S_RRDY] <= 1'b1;
            state        <= ST_RUN;
          end
        end
        ST_STOP: begin
          if (eng_done) begin
            ctl[B_STP] <= 1'b0;
            live       <= cnt_q;
            open_xfer  <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase

      if (cnt_we) cnt_q <= cnt_wdata;
      if (ctl_we) ctl <= ctl_wdata & CTL_KEEP;
      if (abort) begin
        state     <= ST_IDLE;
        open_xfer <= 1'b0;
      end
    end
  end

  a_r12_abort_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !req_valid);

  a_r2_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> !ctl_q[B_STT]);

  a_r5_pop_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_has);

  a_r6_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_room);

  a_r10_data_nack_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && eng_done && !eng_ack && !ctl_we) |=>
      (stat[S_NACK] && !ctl_q[B_STP]));

  a_r5_live_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_live != $past(cnt_live)) |->
      (cnt_live == $past(cnt_live) - ONE || cnt_live == $past(cnt_q)));

endmodule

// File: tb/i2c_xfer_seq_bench.sv
`timescale 1ns/1ps
module i2c_xfer_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        ctl_we = 0;
  logic [15:0] ctl_wdata = 0;
  logic        cnt_we = 0;
  logic [15:0] cnt_wdata = 0;
  logic [6:0]  tgt_addr = 7'h2C;
  logic        data_touch = 0;
  logic [4:0]  stat_clr = 0;
  logic [15:0] ctl_q;
  logic [15:0] cnt_live;
  logic [4:0]  stat;
  logic        req_valid, req_read, tx_pop, tx_flush, rx_push;
  logic [1:0]  req_kind;
  logic [6:0]  req_addr;
  logic [7:0]  req_wdata, rx_byte, tx_byte;
  logic        eng_done = 0, eng_ack = 0;
  logic [7:0]  eng_rdata = 0;
  logic [2:0]  tx_level, rx_level;

  i2c_xfer_seq u_i2c_xfer_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .tgt_addr(tgt_addr),
    .data_touch(data_touch), .stat_clr(stat_clr), .ctl_q(ctl_q),
    .cnt_live(cnt_live), .stat(stat), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_read(req_read),
    .req_wdata(req_wdata), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_rdata(eng_rdata), .tx_level(tx_level), .tx_byte(tx_byte),
    .tx_pop(tx_pop), .tx_flush(tx_flush), .rx_level(rx_level),
    .rx_push(rx_push), .rx_byte(rx_byte));

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] ack_plan = '1;
  logic        eng_hold = 0;
  int          nops = 0;
  int          wait_cnt = 0;
  logic [7:0]  rd_seq = 8'h60;
  logic [1:0]  op_kind [0:15];
  logic [7:0]  op_data [0:15];
  logic        op_rd   [0:15];
  logic [6:0]  op_addr [0:15];

  always @(negedge clk) begin
    if (eng_done) begin
      eng_done <= 1'b0;
      wait_cnt = 0;
    end else if (req_valid && !eng_hold) begin
      wait_cnt = wait_cnt + 1;
      if (wait_cnt == 2) begin
        wait_cnt = 0;
        eng_done <= 1'b1;
        eng_ack  <= ack_plan[nops];
        if (nops < 16) begin
          op_kind[nops] = req_kind;
          op_rd[nops]   = req_read;
          op_addr[nops] = req_addr;
          op_data[nops] = (req_kind == 2'd2) ? rd_seq : req_wdata;
        end
        if (req_kind == 2'd2) begin
          eng_rdata <= rd_seq;
          rd_seq = rd_seq + 8'd1;
        end
        nops = nops + 1;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  logic [7:0] tx_mem [0:3];
  logic [2:0] tx_wr = 0, tx_rd;
  logic [7:0] rx_mem [0:3];
  logic [2:0] rx_lv;
  logic       rx_drain = 0;
  assign tx_level = tx_wr - tx_rd;
  assign tx_byte  = tx_mem[tx_rd[1:0]];
  assign rx_level = rx_lv;

  always @(posedge clk) begin
    if (!rst_n) begin
      tx_rd <= 0;
      rx_lv <= 0;
    end else begin
      if (tx_pop) tx_rd <= tx_rd + 3'd1;
      if (tx_flush) tx_rd <= tx_wr;
      if (rx_push) begin
        rx_mem[rx_lv[1:0]] <= rx_byte;
        rx_lv <= rx_lv + 3'd1;
      end
      if (rx_drain) rx_lv <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    tx_wr = 0;
    nops = 0;
    ack_plan = '1;
    eng_hold = 0;
    rd_seq = 8'h60;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_we = 1; cnt_wdata = v;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic touch();
    @(negedge clk); data_touch = 1;
    @(negedge clk); data_touch = 0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_mem[tx_wr[1:0]] = b;
    tx_wr = tx_wr + 3'd1;
  endtask

  task automatic drain_rx();
    @(negedge clk); rx_drain = 1;
    @(negedge clk); rx_drain = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 5) begin
      @(negedge clk);
      if (req_valid) q = 0; else q++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ctl", ctl_q, 0);
    chk("R1 live", cnt_live, 0);
    chk("R1 stat", stat, 0);
    chk("R1 req", req_valid, 0);
  endtask

  task automatic t_mask();
    do_reset();
    wr_ctl(16'h3F7E);
    chk("R2 masked ctl", ctl_q, 16'h0F06);
    wr_ctl(16'h8001);
    wait_quiet();
    chk("R3 no start without master", nops, 0);
    chk("R2 start reads zero", ctl_q, 16'h8000);
  endtask

  task automatic t_tx_stop();
    do_reset();
    push_tx(8'hA1); push_tx(8'hA2); push_tx(8'hA3);
    wr_cnt(16'd3);
    wr_ctl(16'h8603);
    wait_quiet();
    chk("R3 op count", nops, 5);
    chk("R3 start kind", op_kind[0], 0);
    chk("R3 start addr", op_addr[0], 7'h2C);
    chk("R3 start dir write", op_rd[0], 0);
    chk("R5 byte0", {op_kind[1], op_data[1]}, {2'd1, 8'hA1});
    chk("R5 byte1", {op_kind[2], op_data[2]}, {2'd1, 8'hA2});
    chk("R5 byte2", {op_kind[3], op_data[3]}, {2'd1, 8'hA3});
    chk("R7 stop kind", op_kind[4], 3);
    chk("R7 stop bit cleared", ctl_q, 16'h8600);
    chk("R7 live reloaded", cnt_live, 3);
    chk("R7 tx flushed", tx_level, 0);
    touch();
    wait_quiet();
    chk("R11 closed transfer ignores touch", nops, 5);
  endtask

  task automatic t_tx_hand_back();
    do_reset();
    push_tx(8'h11); push_tx(8'h22);
    wr_cnt(16'd4);
    wr_ctl(16'h8601);
    wait_quiet();
    chk("R5 paused ops", nops, 3);
    chk("R5 live left", cnt_live, 2);
    chk("R5 xrdy set", stat, 5'h10);
    push_tx(8'h33); push_tx(8'h44);
    touch();
    wait_quiet();
    chk("R11 resumed ops", nops, 5);
    chk("R11 resumed byte", op_data[4], 8'h44);
    chk("R8 ardy, xrdy clear", stat, 5'h04);
    chk("R8 master cleared", ctl_q, 16'h8200);
    chk("R8 live zero", cnt_live, 0);
  endtask

  task automatic t_addr_nack();
    do_reset();
    ack_plan[0] = 0;
    push_tx(8'h55);
    wr_cnt(16'd1);
    wr_ctl(16'h8603);
    wait_quiet();
    chk("R4 nack set", stat, 5'h02);
    chk("R4 stop cleared", ctl_q, 16'h8600);
    touch();
    wait_quiet();
    chk("R4 no transfer open", nops, 1);
    @(negedge clk); stat_clr = 5'h1F;
    @(negedge clk); stat_clr = 0;
    chk("R13 status cleared", stat, 0);
  endtask

  task automatic t_data_nack();
    do_reset();
    ack_plan[2] = 0;
    push_tx(8'h01); push_tx(8'h02); push_tx(8'h03);
    wr_cnt(16'd3);
    wr_ctl(16'h8603);
    wait_quiet();
    chk("R10 stopped after nack", nops, 3);
    chk("R10 nack flag", stat, 5'h02);
    chk("R10 stop cleared", ctl_q, 16'h8600);
    chk("R13 live shows progress", cnt_live, 1);
  endtask

  task automatic t_rx_counted();
    do_reset();
    wr_cnt(16'd6);
    wr_ctl(16'h8403);
    wait_quiet();
    chk("R3 read direction", op_rd[0], 1);
    chk("R6 filled ops", nops, 5);
    chk("R6 rrdy", stat, 5'h08);
    chk("R6 live", cnt_live, 2);
    chk("R6 bytes", {rx_mem[0], rx_mem[3]}, {8'h60, 8'h63});
    drain_rx();
    touch();
    wait_quiet();
    chk("R7 rx ops", nops, 8);
    chk("R7 rx stop", op_kind[7], 3);
    chk("R6 tail bytes", {rx_mem[0], rx_mem[1]}, {8'h64, 8'h65});
    chk("R8 rrdy follows held", stat, 5'h08);
    chk("R7 rx reload", cnt_live, 6);
  endtask

  task automatic t_repeat();
    do_reset();
    push_tx(8'hC1); push_tx(8'hC2); push_tx(8'hC3);
    wr_cnt(16'd5);
    wr_ctl(16'h8605);
    wait_quiet();
    chk("R9 rpt tx ops", nops, 4);
    chk("R9 rpt xrdy", stat, 5'h10);
    chk("R9 count untouched", cnt_live, 5);
    wr_ctl(16'h8606);
    touch();
    wait_quiet();
    chk("R9 rpt stop issued", {nops[7:0], 6'd0, op_kind[4]}, {8'd5, 6'd0, 2'd3});
    chk("R9 rpt stop cleared", ctl_q, 16'h8604);
    do_reset();
    wr_cnt(16'd2);
    wr_ctl(16'h8405);
    wait_quiet();
    chk("R9 rpt rx fills to depth", nops, 5);
    chk("R9 rpt rx level", rx_level, 4);
    chk("R9 rpt rrdy", stat, 5'h08);
    chk("R9 rx count ignored", cnt_live, 2);
  endtask

  task automatic t_abort();
    do_reset();
    eng_hold = 1;
    wr_cnt(16'd1);
    wr_ctl(16'h8601);
    repeat (3) @(negedge clk);
    chk("R12 request pending", req_valid, 1);
    wr_ctl(16'h0000);
    chk("R12 request withdrawn", req_valid, 0);
    chk("R12 ctl cleared", ctl_q, 0);
    eng_hold = 0;
    touch();
    wait_quiet();
    chk("R12 no transfer open", nops, 0);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_tx_stop();
    t_tx_hand_back();
    t_addr_nack();
    t_data_nack();
    t_rx_counted();
    t_repeat();
    t_abort();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule